// File: doc/BRIEF.md
# Variable-Page TLB Translation Lookup

This block searches a small, fully associative set of address-translation entries for a 32-bit virtual address. Every entry sits in two words and an 8-bit translation ID. The tag word holds the effective page number, a page-size code and a valid flag. The data word holds the real page number, the write and execute enables and a zone selector. The search runs against all entries at once. Each entry names its own page size, from 1 KB to 16 MB, so one set of entries can mix small and very large mappings.

Each request carries an access kind (read, write or fetch) and a privilege level. The lowest-numbered matching entry wins. Its permissions can be overridden by a 2-bit code taken from a 32-bit zone protection word. The result is then checked against the requested access. The outcome has three kinds: a translation miss (no entry matched), a protection miss (an entry matched but the access is not allowed), or a hit. The outcome is reported one clock after the request, together with the entry index, the physical address and the granted permissions.

Entry contents, the current process ID and the zone word come in as plain inputs. Filling, replacing and walking tables is left to the surrounding logic.

Top module: `tlb_lookup`

## Requirements
- R1: Tag bits [9:7] hold a size code c that sets the page size to 1 KB × 4^c (1 KB up to 16 MB). An entry matches only when the virtual address and the tag's page-number field (bits [31:10]) agree on every bit at or above bit 10+2c.
- R2: An entry whose tag valid bit (bit 6) is 0 never matches.
- R3: An entry with translation ID 0 matches for any process ID. An entry with a nonzero ID matches only when that ID equals `pid`.
- R4: An entry whose size code is below the parameter `MIN_SIZE_CODE` (default 1, i.e. 4 KB) never matches.
- R5: When several entries match, the lowest index is selected and reported on `hit_idx`.
- R6: `paddr` takes bits at and above the page-offset width from the real page number (data bits [31:10]) of the selected entry, and the page-offset bits from the virtual address.
- R7: Data bits [7:4] select zone z, whose code is `zone_prot[31-2z:30-2z]`. The codes work as follows. Code 00: user mode gets no access; supervisor uses the entry bits. Code 01: the entry bits apply. Code 10: user mode uses the entry bits; supervisor gets read, write and execute. Code 11: read, write and execute in both modes.
- R8: A zone number above the parameter `ZONE_MAX` (default 11), or zones disabled by `ZONES_ON`=0, is treated as code 01.
- R9: Under the entry bits, read is always allowed. Write comes from data bit 8 and execute from data bit 9.
- R10: An access kind of 00 is a read, 01 a write, and 1x a fetch. Exactly one of `hit`, `miss_xlate`, `miss_prot` is 1 for a response. On a translation miss, the index, address and permissions are all 0.
- R11: Results appear in registers one cycle after `lookup_valid`, with `rsp_valid` high for that cycle. Without a request the previous results are held. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | Request strobe |
| vaddr | input | 32 | Virtual address |
| access | input | 2 | 00 read, 01 write, 1x fetch |
| user_mode | input | 1 | 1 = user privilege |
| pid | input | 8 | Current process ID |
| zone_prot | input | 32 | Sixteen 2-bit zone codes, zone 0 in bits [31:30] |
| tag_words | input | ENTRIES×32 | Tag word of each entry, entry i at [32i+31:32i] |
| data_words | input | ENTRIES×32 | Data word of each entry |
| tid_bytes | input | ENTRIES×8 | Translation ID of each entry |
| rsp_valid | output | 1 | Response strobe |
| hit | output | 1 | Translated and permitted |
| miss_xlate | output | 1 | No entry matched |
| miss_prot | output | 1 | Matched but access not permitted |
| hit_idx | output | IDX_W | Selected entry index |
| paddr | output | 32 | Physical address |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |

## Verification
The test uses one fixed set of entries. It mixes page sizes of 4 KB, 16 KB, 1 MB and 16 MB, one invalid entry, one undersized entry, two overlapping entries and one entry tied to a process ID. Requests are aimed at each of them in turn. Addresses just outside a page, and process IDs that differ, tell a match apart from a near match. Changing only the privilege level or the zone word under a fixed address tells the four zone codes apart, and an out-of-range zone number shows the forced code. Changing only the access kind on one entry tells a protection miss apart from a hit.

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int ENTRIES       = 8,
  parameter int MIN_SIZE_CODE = 1,
  parameter int ZONE_MAX      = 11,
  parameter bit ZONES_ON      = 1'b1,
  localparam int IDX_W        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lookup_valid,
  input  logic [31:0]          vaddr,
  input  logic [1:0]           access,
  input  logic                 user_mode,
  input  logic [7:0]           pid,
  input  logic [31:0]          zone_prot,
  input  logic [ENTRIES*32-1:0] tag_words,
  input  logic [ENTRIES*32-1:0] data_words,
  input  logic [ENTRIES*8-1:0]  tid_bytes,
  output logic                 rsp_valid,
  output logic                 hit,
  output logic                 miss_xlate,
  output logic                 miss_prot,
  output logic [IDX_W-1:0]     hit_idx,
  output logic [31:0]          paddr,
  output logic                 perm_r,
  output logic                 perm_w,
  output logic                 perm_x
);

  localparam logic [2:0] MIN_CODE = 3'(MIN_SIZE_CODE);
  localparam logic [3:0] ZMAX     = 4'(ZONE_MAX);

  function automatic logic [31:0] size_mask(input logic [2:0] code);
    return 32'hFFFF_FFFF << (6'd10 + {2'b00, code, 1'b0});
  endfunction

  logic [ENTRIES-1:0] match;
  logic [31:0]        ent_data [ENTRIES];
  logic [31:0]        ent_mask [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [31:0] t;
    logic [7:0]  tid;
    logic        unused_tag_lo;
    assign t             = tag_words[i*32 +: 32];
    assign tid           = tid_bytes[i*8 +: 8];
    assign ent_data[i]   = data_words[i*32 +: 32];
    assign ent_mask[i]   = size_mask(t[9:7]);
    assign unused_tag_lo = ^t[5:0];
    assign match[i] = t[6] && (t[9:7] >= MIN_CODE)
                   && (((vaddr ^ {t[31:10], 10'b0}) & ent_mask[i]) == 32'b0)
                   && ((tid == 8'h00) || (tid == pid));
  end

  logic             found;
  logic [IDX_W-1:0] sel;
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  logic [31:0] d, m, zsh;
  logic [3:0]  zsel;
  logic [1:0]  zcode;
  logic [2:0]  ent_rwx, rwx;
  logic        allowed;
  logic        unused_data_lo;

  assign d              = ent_data[sel];
  assign m              = ent_mask[sel];
  assign unused_data_lo = ^d[3:0];
  assign zsel           = d[7:4];
  assign zsh            = zone_prot >> (5'd30 - {zsel, 1'b0});
  assign zcode          = (!ZONES_ON || zsel > ZMAX) ? 2'b01 : zsh[1:0];
  assign ent_rwx        = {1'b1, d[8], d[9]};

  always_comb begin
    unique case (zcode)
      2'b00:   rwx = user_mode ? 3'b000 : ent_rwx;
      2'b01:   rwx = ent_rwx;
      2'b10:   rwx = user_mode ? ent_rwx : 3'b111;
      default: rwx = 3'b111;
    endcase
  end

  assign allowed = access[1] ? rwx[0] : (access[0] ? rwx[1] : rwx[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      hit        <= 1'b0;
      miss_xlate <= 1'b0;
      miss_prot  <= 1'b0;
      hit_idx    <= '0;
      paddr      <= '0;
      {perm_r, perm_w, perm_x} <= 3'b000;
    end else begin
      rsp_valid <= lookup_valid;
      if (lookup_valid) begin
        hit        <= found && allowed;
        miss_xlate <= !found;
        miss_prot  <= found && !allowed;
        hit_idx    <= found ? sel : '0;
        paddr      <= found ? ((d & m) | (vaddr & ~m)) : 32'b0;
        {perm_r, perm_w, perm_x} <= found ? rwx : 3'b000;
      end
    end
  end

  // R11
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> rsp_valid);

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({hit, miss_xlate, miss_prot}) == 1);

  // R10
  miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && miss_xlate) |-> ({perm_r, perm_w, perm_x} == 3'b000 && paddr == 32'b0));

  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> (miss_xlate || paddr[9:0] == $past(vaddr[9:0])));

  // R9
  read_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && access == 2'b00) |=> (hit == perm_r));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lookup_valid && !$past(!rst_n)) |=> $stable(paddr));

endmodule

// File: tb/sim_tlb_lookup.sv
module sim_tlb_lookup;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lookup_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  access = '0;
  logic        user_mode = 1'b0;
  logic [7:0]  pid = '0;
  logic [31:0] zone_prot = '0;
  logic [N*32-1:0] tag_words, data_words;
  logic [N*8-1:0]  tid_bytes;
  logic rsp_valid, hit, miss_xlate, miss_prot, perm_r, perm_w, perm_x;
  logic [W-1:0] hit_idx;
  logic [31:0]  paddr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tlb_lookup u0 (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .vaddr(vaddr),
    .access(access), .user_mode(user_mode), .pid(pid), .zone_prot(zone_prot),
    .tag_words(tag_words), .data_words(data_words), .tid_bytes(tid_bytes),
    .rsp_valid(rsp_valid), .hit(hit), .miss_xlate(miss_xlate), .miss_prot(miss_prot),
    .hit_idx(hit_idx), .paddr(paddr), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  // entries: 0 4KB@0x1000 rw zone0; 1 1MB@0x400000 tid5 rx zone2; 2 invalid;
  // 3 1KB (undersized); 4 16KB@0x10000 rwx zone12; 5 16MB@0x1000000 zone3;
  // 6 duplicate of 0; 7 4KB@0x5000 tid9 rwx zone1
  initial begin
    tag_words  = {32'h000050C0, 32'h000010C0, 32'h010003C0, 32'h00010140,
                  32'h00003040, 32'h00002080, 32'h004002C0, 32'h000010C0};
    data_words = {32'h00077310, 32'h000F0300, 32'h05000030, 32'h003003C0,
                  32'h000A0300, 32'h00090300, 32'h01200220, 32'h00080100};
    tid_bytes  = {8'h09, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05, 8'h00};
  end

  // {vaddr, access, user, pid, zone | hit,mx,mp, idx, paddr, r,w,x}
  localparam logic [115:0] VEC [14] = '{
    {32'h00001234, 2'd0, 1'b0, 8'h00, 32'h5B000000, 3'b100, 3'd0, 32'h00080234, 3'b110},
    {32'h00001234, 2'd2, 1'b0, 8'h00, 32'h5B000000, 3'b001, 3'd0, 32'h00080234, 3'b110},
    {32'h004ABCDE, 2'd2, 1'b1, 8'h05, 32'h5B000000, 3'b100, 3'd1, 32'h012ABCDE, 3'b101},
    {32'h004ABCDE, 2'd2, 1'b1, 8'h06, 32'h5B000000, 3'b010, 3'd0, 32'h00000000, 3'b000},
    {32'h004ABCDE, 2'd1, 1'b0, 8'h05, 32'h5B000000, 3'b100, 3'd1, 32'h012ABCDE, 3'b111},
    {32'h00002010, 2'd0, 1'b0, 8'h00, 32'h5B000000, 3'b010, 3'd0, 32'h00000000, 3'b000},
    {32'h00003010, 2'd0, 1'b0, 8'h00, 32'h5B000000, 3'b010, 3'd0, 32'h00000000, 3'b000},
    {32'h00013ABC, 2'd1, 1'b1, 8'h00, 32'h5B000000, 3'b100, 3'd4, 32'h00303ABC, 3'b111},
    {32'h01FEDCBA, 2'd2, 1'b1, 8'h00, 32'h5B000000, 3'b100, 3'd5, 32'h05FEDCBA, 3'b111},
    {32'h00001FFF, 2'd0, 1'b1, 8'h00, 32'h1B000000, 3'b001, 3'd0, 32'h00080FFF, 3'b000},
    {32'h00001FFF, 2'd0, 1'b0, 8'h00, 32'h1B000000, 3'b100, 3'd0, 32'h00080FFF, 3'b110},
    {32'h00005004, 2'd1, 1'b0, 8'h09, 32'h5B000000, 3'b100, 3'd7, 32'h00077004, 3'b111},
    {32'h00005004, 2'd1, 1'b0, 8'h00, 32'h5B000000, 3'b010, 3'd0, 32'h00000000, 3'b000},
    {32'h00000FFF, 2'd0, 1'b0, 8'h00, 32'h5B000000, 3'b010, 3'd0, 32'h00000000, 3'b000}
  };

  function automatic string tag_of(int k);
    case (k)
      0: return "R1 R5 R9";  1: return "R10";  2: return "R3 R7";
      3: return "R3";        4: return "R7";   5: return "R2";
      6: return "R4";        7: return "R8";   8: return "R1 R7";
      9: return "R7";        10: return "R7";  11: return "R3 R6";
      12: return "R3";       default: return "R1";
    endcase
  endfunction

  function automatic logic [40:0] outs();
    return {rsp_valid, hit, miss_xlate, miss_prot, hit_idx, paddr, perm_r, perm_w, perm_x};
  endfunction

  task automatic compare(string req, logic [40:0] act, logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    compare("R11 reset", outs(), 41'b0);
    rst_n = 1'b1;

    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      {vaddr, access, user_mode, pid, zone_prot} = VEC[k][115:41];
      lookup_valid = 1'b1;
      @(negedge clk);
      lookup_valid = 1'b0;
      compare(tag_of(k), outs(), {1'b1, VEC[k][40:0]});
    end

    // R11 hold without request: last vector result stays, strobe drops
    vaddr = 32'h00001234;
    @(negedge clk);
    compare("R11 hold", outs(), {1'b0, VEC[13][40:0]});

    // R5 lowest index wins even with entry 0 disabled by pid-independent path
    tag_words[31:0] = 32'h00001080;
    lookup_valid = 1'b1; access = 2'd0; user_mode = 1'b0; zone_prot = 32'h5B000000;
    @(negedge clk);
    lookup_valid = 1'b0;
    compare("R5 fallback idx6", outs(), {1'b1, 3'b100, 3'd6, 32'h000F0234, 3'b111});
    tag_words[31:0] = 32'h000010C0;

    // R11 reset clears after activity
    rst_n = 1'b0;
    @(negedge clk);
    compare("R11 reset clear", outs(), 41'b0);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule